// File: doc/BRIEF.md
# Per-Burst CRC-8 Link Error Detector

This block protects one byte lane of a high-speed memory link. Every burst is eight beats, and each beat carries eight data bits plus the lane's inversion flag. The block folds all of those bits into a CRC-8 checksum and shifts the checksum out, most significant bit first, on a dedicated serial error-detect line. While no checksum is being sent, the line carries a clock-like hold pattern that toggles on every cycle.

The same RTL serves both ends of the link. The memory-side copy (`CHECK_EN = 0`) only generates and serializes the checksum. It never judges the data: the memory carries out the command whatever the checksum says. The controller-side copy (`CHECK_EN = 1`) also captures the serial checksum that arrives from the far end and compares it with its own result. On a mismatch it raises a one-cycle reissue request next to a burst-done pulse. A retry scheduler outside this block then repeats the failing command.

Top module: `burst_crc_lane`

## Requirements
- R1: While reset is asserted, and in the cycle it is released, `edc_out` is 1 and `chk_done` and `reissue_req` are 0.
- R2: Whenever no checksum is being serialized, `edc_out` follows a hold pattern that inverts on every clock cycle (1,0,1,0,...). The hold pattern runs freely underneath the serialization windows.
- R3: The checksum uses the generator x^8+x^2+x+1 (0x07) and starts from zero for each burst. Each beat contributes the 9-bit word {beat_inv, beat_data[7:0]}, MSB first, so the inversion flag enters first. After the clock edge that accepts the eighth beat, `edc_out` presents checksum bits 7 down to 0, one per cycle, over the next eight cycles.
- R4: Any single-bit or double-bit corruption of the 72 data and inversion bits that the controller side sees, compared with what the sender checksummed, produces `reissue_req`.
- R5: Cycles with `beat_valid` low neither advance the beat position nor change the checksum, whatever `beat_data` and `beat_inv` hold.
- R6: The controller side samples `edc_in` on the eight clock edges that follow the edge accepting the eighth beat, MSB first. One cycle after the last sample it pulses `chk_done` for one cycle, with `reissue_req` high in that same cycle if and only if the received checksum differs from the local one.
- R7: Bursts may follow back to back with no idle beat. The next checksum then starts on `edc_out` in the cycle right after the last bit of the previous one, and both bursts are checked.
- R8: With `CHECK_EN = 0`, `chk_done` and `reissue_req` stay 0 while `edc_out` behaves as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | A burst beat is present this cycle |
| beat_data | input | DATA_W | Data bits of the beat |
| beat_inv | input | 1 | Inversion flag of the beat |
| edc_in | input | 1 | Serial checksum received from the far end (controller side) |
| edc_out | output | 1 | Serial checksum or idle hold pattern |
| chk_done | output | 1 | One-cycle pulse when a received checksum has been compared |
| reissue_req | output | 1 | One-cycle pulse with chk_done when the checksums differ |

## Verification
Two copies run in lock step: a memory-side instance fed clean beats and a controller-side instance fed the same beats with deliberate corruption, with its `edc_in` taken from the memory side's output. Fixed patterns (all zero, all one, ramps, inversion-only) pin down the polynomial and the bit order, and the inversion-only pattern shows that the flag is covered. An exhaustive sweep of every single and every double flip across the 72 burst bits checks the detection claim. Flips injected on the serial line show that the received bits are compared in the right order. Paused bursts with junk on the idle beats, back-to-back bursts and idle stretches separate beat gating, window overlap and hold-pattern continuity.

// File: rtl/burst_crc_pkg.sv
package burst_crc_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int              LANE_DATA_W = 8;
   localparam int              BURST_BEATS = 8;
   localparam int              CRC_WIDTH   = 8;
   localparam logic [7:0]      CRC_POLY    = 8'h07;
   localparam bit              HOLD_FIRST  = 1'b1;
endpackage

// File: rtl/crc_word_step.sv
module crc_word_step #(
   parameter int                 CRC_W  = 8,
   parameter int                 WORD_W = 9,
   parameter logic [CRC_W-1:0]   POLY   = 8'h07
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [WORD_W-1:0] word,
   output logic [CRC_W-1:0]  crc_out
);
   timeunit 1ns;
   timeprecision 1ps;

   // One bit per stage, word MSB first.
   for (genvar i = 0; i < WORD_W; i++) begin : stg
      logic [CRC_W-1:0] prev;
      logic [CRC_W-1:0] q;
      logic             fb;
      if (i == 0) begin : g_first
         assign prev = crc_in;
      end else begin : g_next
         assign prev = stg[i-1].q;
      end
      assign fb = prev[CRC_W-1] ^ word[WORD_W-1-i];
      assign q  = {prev[CRC_W-2:0], 1'b0} ^ (fb ? POLY : {CRC_W{1'b0}});
   end

   assign crc_out = stg[WORD_W-1].q;
endmodule

// File: rtl/burst_accumulator.sv
module burst_accumulator #(
   parameter int                 CRC_W  = 8,
   parameter int                 WORD_W = 9,
   parameter int                 BEATS  = 8,
   parameter logic [CRC_W-1:0]   POLY   = 8'h07,
   localparam int                CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic [WORD_W-1:0] word,
   output logic [CNT_W-1:0]  beat_idx,
   output logic              fin_now,
   output logic [CRC_W-1:0]  fin_crc
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

   logic [CRC_W-1:0] acc;
   logic [CRC_W-1:0] base;
   logic [CRC_W-1:0] next_crc;

   assign base = (beat_idx == '0) ? {CRC_W{1'b0}} : acc;

   crc_word_step #(.CRC_W(CRC_W), .WORD_W(WORD_W), .POLY(POLY)) u_step (
      .crc_in  (base),
      .word    (word),
      .crc_out (next_crc)
   );

   assign fin_now = beat_valid && (beat_idx == LAST);
   assign fin_crc = next_crc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_idx <= '0;
         acc      <= '0;
      end else if (beat_valid) begin
         if (beat_idx == LAST) begin
            beat_idx <= '0;
         end else begin
            beat_idx <= beat_idx + 1'b1;
         end
         acc <= next_crc;
      end
   end
endmodule

// File: rtl/edc_serializer.sv
module edc_serializer #(
   parameter int CRC_W     = 8,
   parameter bit HOLD_INIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CRC_W-1:0] load_val,
   output logic             busy,
   output logic             edc_out
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LW = $clog2(CRC_W + 1);

   logic [CRC_W-1:0] sh;
   logic [LW-1:0]    left;
   logic             hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         left <= '0;
         hold <= HOLD_INIT;
      end else begin
         hold <= ~hold;
         if (load) begin
            sh   <= load_val;
            left <= LW'(CRC_W);
         end else if (left != '0) begin
            sh   <= {sh[CRC_W-2:0], 1'b0};
            left <= left - 1'b1;
         end
      end
   end

   assign busy    = (left != '0);
   assign edc_out = busy ? sh[CRC_W-1] : hold;
endmodule

// File: rtl/edc_comparator.sv
module edc_comparator #(
   parameter int CRC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [CRC_W-1:0] exp_in,
   input  logic             edc_in,
   output logic             chk_done,
   output logic             chk_err
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LW = $clog2(CRC_W + 1);

   logic [CRC_W-1:0] expect_q;
   logic [CRC_W-1:0] rx;
   logic [CRC_W-1:0] rx_next;
   logic [LW-1:0]    left;

   assign rx_next = {rx[CRC_W-2:0], edc_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         expect_q <= '0;
         rx       <= '0;
         left     <= '0;
         chk_done <= 1'b0;
         chk_err  <= 1'b0;
      end else begin
         chk_done <= 1'b0;
         chk_err  <= 1'b0;
         if (left != '0) begin
            rx   <= rx_next;
            left <= left - 1'b1;
            if (left == LW'(1)) begin
               chk_done <= 1'b1;
               chk_err  <= (rx_next != expect_q);
            end
         end
         if (arm) begin
            expect_q <= exp_in;
            left     <= LW'(CRC_W);
         end
      end
   end
endmodule

// File: rtl/burst_crc_lane.sv
module burst_crc_lane
   import burst_crc_pkg::*;
#(
   parameter int                 DATA_W    = LANE_DATA_W,
   parameter int                 BEATS     = BURST_BEATS,
   parameter int                 CRC_W     = CRC_WIDTH,
   parameter logic [CRC_W-1:0]   POLY      = CRC_W'(CRC_POLY),
   parameter bit                 HOLD_INIT = HOLD_FIRST,
   parameter bit                 CHECK_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic [DATA_W-1:0] beat_data,
   input  logic              beat_inv,
   input  logic              edc_in,
   output logic              edc_out,
   output logic              chk_done,
   output logic              reissue_req
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int WORD_W = DATA_W + 1;
   localparam int CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (CRC_W < 2) begin : g_bad_crc_w
      $error("CRC_W must be at least 2");
   end
   if (BEATS < CRC_W) begin : g_bad_beats
      $error("BEATS must cover the serial checksum window");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("POLY must have its constant term set");
   end

   logic [WORD_W-1:0] word;
   logic [CNT_W-1:0]  beat_idx;
   logic              fin_now;
   logic [CRC_W-1:0]  fin_crc;
   logic              tx_busy;

   assign word = {beat_inv, beat_data};

   burst_accumulator #(
      .CRC_W(CRC_W), .WORD_W(WORD_W), .BEATS(BEATS), .POLY(POLY)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (beat_valid),
      .word       (word),
      .beat_idx   (beat_idx),
      .fin_now    (fin_now),
      .fin_crc    (fin_crc)
   );

   edc_serializer #(.CRC_W(CRC_W), .HOLD_INIT(HOLD_INIT)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fin_now),
      .load_val (fin_crc),
      .busy     (tx_busy),
      .edc_out  (edc_out)
   );

   if (CHECK_EN) begin : g_ctrl
      edc_comparator #(.CRC_W(CRC_W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .arm      (fin_now),
         .exp_in   (fin_crc),
         .edc_in   (edc_in),
         .chk_done (chk_done),
         .chk_err  (reissue_req)
      );
   end else begin : g_dev
      logic unused_rx;
      assign unused_rx   = edc_in;
      assign chk_done    = 1'b0;
      assign reissue_req = 1'b0;
   end
endmodule

// File: rtl/burst_crc_lane_chk.sv
module burst_crc_lane_chk #(
   parameter bit CHECK_EN = 1'b1,
   parameter int BEATS    = 8,
   localparam int CNT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             beat_valid,
   input logic [CNT_W-1:0] beat_idx,
   input logic             fin_now,
   input logic             tx_busy,
   input logic             edc_out,
   input logic             chk_done,
   input logic             reissue_req
);
   timeunit 1ns;
   timeprecision 1ps;

   // R2: two idle cycles in a row must show opposite levels
   assert_hold_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !tx_busy && $past(!tx_busy)) |-> (edc_out != $past(edc_out)));

   // R3: accepting the last beat starts serialization on the next cycle
   assert_tx_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fin_now |=> tx_busy);

   // R5: an empty beat slot keeps the beat position
   assert_pause_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid |=> $stable(beat_idx));

   // R6: done is a single-cycle pulse
   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |=> !chk_done);

   // R6: a reissue request only comes with a completed compare
   assert_req_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reissue_req |-> chk_done);

   // R8: the memory-side variant never reports
   assert_dev_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !CHECK_EN |-> (!chk_done && !reissue_req));
endmodule

bind burst_crc_lane burst_crc_lane_chk #(.CHECK_EN(CHECK_EN), .BEATS(BEATS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .beat_valid  (beat_valid),
   .beat_idx    (beat_idx),
   .fin_now     (fin_now),
   .tx_busy     (tx_busy),
   .edc_out     (edc_out),
   .chk_done    (chk_done),
   .reissue_req (reissue_req)
);

// File: tb/burst_crc_lane_test.sv
module burst_crc_lane_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       bv = 1'b0;
   logic [7:0] cdata = '0, ddata = '0;
   logic       cinv = 1'b0, dinv = 1'b0;
   logic       eflip_now = 1'b0;
   logic       dev_edc, dev_done, dev_req;
   logic       uut_edc, uut_done, uut_req;
   logic       edc_link;

   assign edc_link = dev_edc ^ eflip_now;

   burst_crc_lane #(.CHECK_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .beat_valid(bv), .beat_data(cdata), .beat_inv(cinv),
      .edc_in(edc_link), .edc_out(uut_edc), .chk_done(uut_done), .reissue_req(uut_req));

   burst_crc_lane #(.CHECK_EN(1'b0)) u_dev (
      .clk(clk), .rst_n(rst_n), .beat_valid(bv), .beat_data(ddata), .beat_inv(dinv),
      .edc_in(1'b0), .edc_out(dev_edc), .chk_done(dev_done), .reissue_req(dev_req));

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic       live [2];
   int         se   [2];
   logic [7:0] sdev [2];
   logic [7:0] sloc [2];
   logic [7:0] sflp [2];
   string      stag [2];
   logic       prev_idle = 1'b0;
   logic       prev_edc  = 1'b0;

   function automatic logic [7:0] crc72(input logic [71:0] s);
      logic [7:0] c = 8'h00;
      logic       fb;
      for (int i = 71; i >= 0; i--) begin
         fb = c[7] ^ s[i];
         c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return c;
   endfunction

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic observe();
      logic in_win = 1'b0;
      logic flip_nx = 1'b0;
      logic done_exp = 1'b0;
      logic err_exp = 1'b0;
      string dtag = "R6";
      for (int s = 0; s < 2; s++) begin
         if (live[s]) begin
            int d = cyc - se[s];
            if (d >= 0 && d <= 7) begin
               in_win  = 1'b1;
               flip_nx = sflp[s][7-d];
               chk(dev_edc == sdev[s][7-d], stag[s], "memory-side checksum bit", dev_edc, sdev[s][7-d]);
               chk(uut_edc == sloc[s][7-d], stag[s], "controller-side checksum bit", uut_edc, sloc[s][7-d]);
            end
            if (d == 8) begin
               done_exp = 1'b1;
               err_exp  = (sloc[s] != (sdev[s] ^ sflp[s]));
               dtag     = stag[s];
               live[s]  = 1'b0;
            end
         end
      end
      eflip_now = in_win ? flip_nx : 1'b0;
      chk(uut_done == done_exp, "R6", "chk_done", uut_done, done_exp);
      chk(uut_req == err_exp, dtag, "reissue_req", uut_req, err_exp);
      chk(!dev_done && !dev_req, "R8", "memory-side report outputs", {dev_done, dev_req}, 0);
      if (!in_win) begin
         chk(uut_edc == dev_edc, "R2", "hold phase equal on both sides", uut_edc, dev_edc);
         if (prev_idle) chk(dev_edc != prev_edc, "R2", "hold pattern toggle", dev_edc, !prev_edc);
      end
      prev_idle = !in_win;
      prev_edc  = dev_edc;
   endtask

   task automatic cycle(input logic v, input logic [8:0] cw, input logic [8:0] dw,
                        input logic last, input logic [7:0] lcrc, input logic [7:0] dcrc,
                        input logic [7:0] flip, input string tag);
      observe();
      bv    = v;
      cdata = cw[7:0]; cinv = cw[8];
      ddata = dw[7:0]; dinv = dw[8];
      if (last) begin
         int s = live[0] ? 1 : 0;
         live[s] = 1'b1; se[s] = cyc + 1;
         sloc[s] = lcrc; sdev[s] = dcrc; sflp[s] = flip; stag[s] = tag;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cycle(1'b0, 9'h1A5 ^ 9'(k), 9'h05A ^ 9'(k), 1'b0, 8'h0, 8'h0, 8'h0, "R2");
   endtask

   task automatic burst(input logic [71:0] clean, input logic [71:0] corr,
                        input logic [7:0] flip, input int gap, input string tag);
      logic [7:0] lcrc = crc72(clean ^ corr);
      logic [7:0] dcrc = crc72(clean);
      for (int b = 0; b < 8; b++) begin
         logic [8:0] w  = clean[71-9*b -: 9];
         logic [8:0] cw = w ^ corr[71-9*b -: 9];
         cycle(1'b1, cw, w, b == 7, lcrc, dcrc, flip, tag);
         if (b != 7) begin
            for (int g = 0; g < gap; g++)
               cycle(1'b0, 9'h1FF ^ 9'(g * 37 + b), 9'h0F0 ^ 9'(b), 1'b0, 8'h0, 8'h0, 8'h0, tag);
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      live[0] = 1'b0; live[1] = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk(uut_edc == 1'b1 && dev_edc == 1'b1, "R1", "edc_out in reset", {uut_edc, dev_edc}, 2'b11);
         chk(!uut_done && !uut_req, "R1", "report outputs in reset", {uut_done, uut_req}, 0);
      end
      rst_n = 1'b1;
      chk(uut_edc == 1'b1, "R1", "edc_out at release", uut_edc, 1);
      @(posedge clk);
      cyc++;
      @(negedge clk);
      chk(uut_edc == 1'b0, "R2", "hold phase after first edge", uut_edc, 0);

      idle(6);
      // R3 fixed patterns, including inversion-only coverage
      burst(72'h0, 72'h0, 8'h00, 0, "R3");
      idle(3);
      burst({72{1'b1}}, 72'h0, 8'h00, 0, "R3");
      idle(2);
      burst(72'h0123456789ABCDEF01, 72'h0, 8'h00, 0, "R3");
      idle(1);
      burst({8{9'h100}}, 72'h0, 8'h00, 0, "R3");
      idle(4);
      // R5 paused bursts with junk on empty slots
      burst(72'hF0E1D2C3B4A5968778, 72'h0, 8'h00, 1, "R5");
      burst(72'h5A5A5A5A5A5A5A5A5A, 72'h0, 8'h00, 3, "R5");
      idle(5);
      // R7 back to back
      burst(72'h111111111111111111, 72'h0, 8'h00, 0, "R7");
      burst(72'h8040201008040201FF, 72'h0, 8'h00, 0, "R7");
      burst(72'hDEADBEEFCAFEF00D12, 72'h0, 8'h00, 0, "R7");
      idle(9);
      // R6 flips on the serial line, one bit position at a time
      for (int k = 0; k < 8; k++) burst(72'h3C3C3C3C3C3C3C3C3C ^ 72'(k), 72'h0, 8'(1 << k), k % 2, "R6");
      idle(9);
      // R4 exhaustive single and double corruption sweep
      for (int i = 0; i < 72; i++)
         burst({9{8'h96 ^ 8'(i)}}, 72'b1 << i, 8'h00, 0, "R4");
      for (int i = 0; i < 72; i++)
         for (int j = i + 1; j < 72; j++)
            burst({9{8'h3C ^ 8'(i)}}, (72'b1 << i) | (72'b1 << j), 8'h00, 0, "R4");
      idle(12);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule